// File: doc/BRIEF.md
# Shared-Counter Capture/Compare Timer

This block is a general-purpose timing unit built around a single free-running up-counter. A prescaler sets how fast the counter runs. Every capture and compare channel works from that one time base, so timestamps taken on one channel can be compared directly with events scheduled on another.

Three input-capture channels watch external pins. Each pin first passes through a two-flop synchroniser. When the selected edge is seen, the channel stores the counter value and raises its flag. Five output-compare channels each own one output pin and one compare register. When the counter reaches the programmed value, the channel sets, clears or toggles its pin, or leaves it unchanged, and raises its flag in every case. A counter wrap raises an overflow flag.

Software reaches the timer through a small synchronous register port with a one-clock read latency. Flags are cleared by writing 1 to them. A single interrupt output is the OR of every flag whose enable bit is set.

Top module: `cc_timer`

## Requirements
- R1: The counter is 16 bits wide and shared by all channels. It resets to 0 and increases by exactly 1 on each prescaler tick, wrapping from 0xFFFF to 0x0000. It reads at address 0.
- R2: Bits [1:0] of the control register (address 9) select the tick rate: 0 gives every clock, 1 every 4th clock, 2 every 8th clock and 3 every 16th clock. Over any 64-clock window the counter therefore advances by 64, 16, 8 or 4.
- R3: Capture channel i (i = 0..2) takes its edge mode from control bits [2+2i+1 : 2+2i]: 0 disabled, 1 rising, 2 falling, 3 both. Only a selected edge loads capture register i (addresses 1..3) and sets its flag. A disabled channel or an unselected edge leaves both the register and the flag unchanged.
- R4: With a tick every clock, a capture stores the counter value seen two rising clock edges after the pin changes. Before a capture, the capture register reads 0.
- R5: Compare channel j (j = 0..4) has a compare register at address 4+j and an action in action-register bits [2j+1:2j] (address 10): 0 none, 1 toggle, 2 clear, 3 set. One clock after the counter first shows the compare value, the action is applied to output pin j and flag bit 3+j is set. The flag is set even when the action is none.
- R6: A compare value written on a clock edge is used for matching from the next clock. With a tick every clock, this lets a toggling channel produce a high pulse exactly one clock wide.
- R7: A counter wrap sets overflow flag bit 8.
- R8: The flag register (address 11) holds capture flags in bits 0..2, compare flags in bits 3..7 and overflow in bit 8. Writing 1 to a bit clears it. Writing 0 has no effect.
- R9: The interrupt output is registered. One clock after any flag is set whose enable bit is also set (enable register, address 12, same bit layout), it goes high. It falls one clock after no enabled flag remains.
- R10: Read data is registered and shows the addressed register one clock after the address is presented. Writes to the counter and capture addresses are ignored.
- R11: After reset, all output pins, the interrupt, the flags and the capture registers are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| we | input | 1 | Register write strobe |
| addr | input | 4 | Register address for read and write |
| wdata | input | 16 | Register write data |
| rdata | output | 16 | Registered read data |
| ic_pin | input | 3 | Asynchronous capture inputs |
| oc_pin | output | 5 | Compare-driven output pins |
| irq | output | 1 | Registered interrupt request |

## Verification
The bench predicts exact capture timestamps from the known synchroniser depth. A design with one flop too many or too few in the capture path would store a value one count off. It also moves a compare register on the very clock its match fires, to obtain a one-clock pulse. A design that matched on a stale or a pre-registered compare value would produce a pulse of zero or two clocks. Other checks cover an unselected capture edge, which must leave the register at its old value, and an action of none, which must still raise the flag. The remaining checks cover the exact 0xFFFF-to-0 wrap and writing 0 to the flag register, which must neither clear a flag nor drop the interrupt.

// File: rtl/cct_pkg.sv
package cct_pkg;

  typedef enum logic [1:0] {
    EDGE_OFF  = 2'd0,
    EDGE_RISE = 2'd1,
    EDGE_FALL = 2'd2,
    EDGE_BOTH = 2'd3
  } edge_sel_e;

  typedef enum logic [1:0] {
    ACT_NONE   = 2'd0,
    ACT_TOGGLE = 2'd1,
    ACT_CLEAR  = 2'd2,
    ACT_SET    = 2'd3
  } oc_act_e;

  localparam int PRE_W = 4;

  // mask of prescaler bits that must all be one for a tick
  function automatic logic [PRE_W-1:0] div_mask(input logic [1:0] sel);
    case (sel)
      2'd0:    div_mask = 4'b0000;
      2'd1:    div_mask = 4'b0011;
      2'd2:    div_mask = 4'b0111;
      default: div_mask = 4'b1111;
    endcase
  endfunction

endpackage

// File: rtl/cct_timebase.sv
module cct_timebase import cct_pkg::*; #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       div_sel,
  output logic [CNT_W-1:0] cnt_q,
  output logic             tick,
  output logic             inc_q,
  output logic             wrap
);

  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] mask;

  assign mask = div_mask(div_sel);
  assign tick = ((pre_q & mask) == mask);
  assign wrap = tick && (&cnt_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      pre_q <= '0;
      cnt_q <= '0;
      inc_q <= 1'b0;
    end else begin
      pre_q <= pre_q + 1'b1;
      inc_q <= tick;
      if (tick) cnt_q <= cnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/cct_capture.sv
module cct_capture import cct_pkg::*; #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pin,
  input  logic [1:0]       sel,
  input  logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] cap_q,
  output logic             hit
);

  logic s1_q, s2_q, s3_q;
  logic rise, fall;
  edge_sel_e mode;

  assign mode = edge_sel_e'(sel);
  assign rise = s2_q & ~s3_q;
  assign fall = ~s2_q & s3_q;

  always_comb begin
    case (mode)
      EDGE_RISE: hit = rise;
      EDGE_FALL: hit = fall;
      EDGE_BOTH: hit = rise | fall;
      default:   hit = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_q  <= 1'b0;
      s2_q  <= 1'b0;
      s3_q  <= 1'b0;
      cap_q <= '0;
    end else begin
      s1_q <= pin;
      s2_q <= s1_q;
      s3_q <= s2_q;
      if (hit) cap_q <= cnt;
    end
  end

endmodule

// File: rtl/cct_compare.sv
module cct_compare import cct_pkg::*; #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inc_q,
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] cmp_val,
  input  logic [1:0]       act,
  output logic             pin_q,
  output logic             hit
);

  oc_act_e mode;

  assign mode = oc_act_e'(act);
  // fires once per counter value: only on the clock after an increment
  assign hit  = inc_q && (cnt == cmp_val);

  always_ff @(posedge clk) begin
    if (rst) begin
      pin_q <= 1'b0;
    end else if (hit) begin
      case (mode)
        ACT_TOGGLE: pin_q <= ~pin_q;
        ACT_CLEAR:  pin_q <= 1'b0;
        ACT_SET:    pin_q <= 1'b1;
        default:    pin_q <= pin_q;
      endcase
    end
  end

endmodule

// File: rtl/cc_timer.sv
module cc_timer import cct_pkg::*; #(
  parameter int CNT_W  = 16,
  parameter int N_IC   = 3,
  parameter int N_OC   = 5,
  parameter int DATA_W = 16,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic [N_IC-1:0]   ic_pin,
  output logic [N_OC-1:0]   oc_pin,
  output logic              irq
);

  localparam int CTRL_W = 2 + 2*N_IC;
  localparam int ACT_W  = 2*N_OC;
  localparam int FLAG_W = N_IC + N_OC + 1;
  localparam int A_CNT  = 0;
  localparam int A_CAP0 = 1;
  localparam int A_CMP0 = A_CAP0 + N_IC;
  localparam int A_CTRL = A_CMP0 + N_OC;
  localparam int A_ACT  = A_CTRL + 1;
  localparam int A_FLAG = A_ACT + 1;
  localparam int A_EN   = A_FLAG + 1;

  logic [CTRL_W-1:0] ctrl_q;
  logic [ACT_W-1:0]  act_q;
  logic [FLAG_W-1:0] flag_q;
  logic [FLAG_W-1:0] en_q;
  logic [FLAG_W-1:0] flag_set;
  logic [FLAG_W-1:0] flag_clr;
  logic [DATA_W-1:0] rd_mux;
  logic [DATA_W-1:0] rdata_q;
  logic              irq_q;

  logic [CNT_W-1:0]  cnt_q;
  logic              tick;
  logic              inc_q;
  logic              wrap;

  logic [CNT_W-1:0]  cap_val [N_IC];
  logic [N_IC-1:0]   ic_hit;
  logic [CNT_W-1:0]  cmp_q   [N_OC];
  logic [N_OC-1:0]   oc_hit;

  cct_timebase #(.CNT_W(CNT_W)) u_tb (
    .clk     (clk),
    .rst     (rst),
    .div_sel (ctrl_q[1:0]),
    .cnt_q   (cnt_q),
    .tick    (tick),
    .inc_q   (inc_q),
    .wrap    (wrap)
  );

  for (genvar i = 0; i < N_IC; i++) begin : g_ic
    cct_capture #(.CNT_W(CNT_W)) u_cap (
      .clk   (clk),
      .rst   (rst),
      .pin   (ic_pin[i]),
      .sel   (ctrl_q[2+2*i +: 2]),
      .cnt   (cnt_q),
      .cap_q (cap_val[i]),
      .hit   (ic_hit[i])
    );
  end

  for (genvar j = 0; j < N_OC; j++) begin : g_oc
    always_ff @(posedge clk) begin
      if (rst)                                   cmp_q[j] <= '0;
      else if (we && addr == ADDR_W'(A_CMP0+j))  cmp_q[j] <= wdata[CNT_W-1:0];
    end

    cct_compare #(.CNT_W(CNT_W)) u_cmp (
      .clk     (clk),
      .rst     (rst),
      .inc_q   (inc_q),
      .cnt     (cnt_q),
      .cmp_val (cmp_q[j]),
      .act     (act_q[2*j +: 2]),
      .pin_q   (oc_pin[j]),
      .hit     (oc_hit[j])
    );
  end

  assign flag_set = {wrap, oc_hit, ic_hit};
  assign flag_clr = (we && addr == ADDR_W'(A_FLAG)) ? wdata[FLAG_W-1:0] : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
      act_q  <= '0;
      en_q   <= '0;
      flag_q <= '0;
    end else begin
      if (we && addr == ADDR_W'(A_CTRL)) ctrl_q <= wdata[CTRL_W-1:0];
      if (we && addr == ADDR_W'(A_ACT))  act_q  <= wdata[ACT_W-1:0];
      if (we && addr == ADDR_W'(A_EN))   en_q   <= wdata[FLAG_W-1:0];
      // a new event in the same clock outranks a clear
      flag_q <= (flag_q & ~flag_clr) | flag_set;
    end
  end

  always_comb begin
    rd_mux = '0;
    if (addr == ADDR_W'(A_CNT))  rd_mux = DATA_W'(cnt_q);
    if (addr == ADDR_W'(A_CTRL)) rd_mux = DATA_W'(ctrl_q);
    if (addr == ADDR_W'(A_ACT))  rd_mux = DATA_W'(act_q);
    if (addr == ADDR_W'(A_FLAG)) rd_mux = DATA_W'(flag_q);
    if (addr == ADDR_W'(A_EN))   rd_mux = DATA_W'(en_q);
    for (int i = 0; i < N_IC; i++)
      if (addr == ADDR_W'(A_CAP0+i)) rd_mux = DATA_W'(cap_val[i]);
    for (int j = 0; j < N_OC; j++)
      if (addr == ADDR_W'(A_CMP0+j)) rd_mux = DATA_W'(cmp_q[j]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
      irq_q   <= 1'b0;
    end else begin
      rdata_q <= rd_mux;
      irq_q   <= |(flag_q & en_q);
    end
  end

  assign rdata = rdata_q;
  assign irq   = irq_q;

endmodule

// File: rtl/cc_timer_chk.sv
module cc_timer_chk #(
  parameter int CNT_W  = 16,
  parameter int N_OC   = 5,
  parameter int FLAG_W = 9
) (
  input logic              clk,
  input logic              rst,
  input logic              tick,
  input logic              wrap,
  input logic [1:0]        div_sel,
  input logic [CNT_W-1:0]  cnt,
  input logic [FLAG_W-1:0] flags,
  input logic [FLAG_W-1:0] en,
  input logic [N_OC-1:0]   oc_pin,
  input logic [N_OC-1:0]   oc_hit,
  input logic              irq
);

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
    tick |=> cnt == CNT_W'($past(cnt) + 1'b1)); // R1

  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(cnt)); // R1

  AST_DIV4_GAP: assert property (@(posedge clk) disable iff (rst)
    (div_sel == 2'd1 && tick) |=> (!tick || div_sel != 2'd1)); // R2

  AST_PIN_ON_HIT: assert property (@(posedge clk) disable iff (rst)
    ((oc_pin ^ $past(oc_pin)) & ~$past(oc_hit)) == '0); // R5

  AST_OVF_FLAG: assert property (@(posedge clk) disable iff (rst)
    wrap |=> flags[FLAG_W-1]); // R7

  AST_IRQ_RISE: assert property (@(posedge clk) disable iff (rst)
    (|(flags & en)) |=> irq); // R9

  AST_IRQ_FALL: assert property (@(posedge clk) disable iff (rst)
    !(|(flags & en)) |=> !irq); // R9

endmodule

bind cc_timer cc_timer_chk #(
  .CNT_W  (CNT_W),
  .N_OC   (N_OC),
  .FLAG_W (FLAG_W)
) u_chk (
  .clk     (clk),
  .rst     (rst),
  .tick    (tick),
  .wrap    (wrap),
  .div_sel (ctrl_q[1:0]),
  .cnt     (cnt_q),
  .flags   (flag_q),
  .en      (en_q),
  .oc_pin  (oc_pin),
  .oc_hit  (oc_hit),
  .irq     (irq)
);

// File: tb/cc_timer_tb.sv
module cc_timer_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        we = 1'b0;
  logic [3:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [2:0]  ic_pin = '0;
  logic [15:0] rdata;
  logic [4:0]  oc_pin;
  logic        irq;

  int          checks = 0;
  int          errors = 0;
  logic [31:0] edges;
  logic [15:0] act_sh = '0;

  cc_timer u_dut (
    .clk(clk), .rst(rst), .we(we), .addr(addr), .wdata(wdata),
    .rdata(rdata), .ic_pin(ic_pin), .oc_pin(oc_pin), .irq(irq)
  );

  always #5 clk = ~clk;

  // bench time base: clock edges since reset release
  always_ff @(posedge clk) edges <= rst ? 32'd0 : edges + 1;

  function automatic logic [15:0] now16();
    return edges[15:0];
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // all tasks start and end on a falling edge
  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] d);
    addr = a;
    @(negedge clk);
    d = rdata;
  endtask

  task automatic wait_cnt(input logic [15:0] v);
    while (now16() != v) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [15:0] v, e;
    chk("R11 oc pins", oc_pin, 0);
    chk("R11 irq", irq, 0);
    rd(11, v); chk("R11 flags", v, 0);
    rd(1, v);  chk("R4 capture before event", v, 0);
    wr(0, 16'h1234);
    rd(2, v);  // pipeline settle
    e = now16();
    rd(0, v);  chk("R10 counter write ignored / R1 count", v, e);
  endtask

  task automatic t_capture();
    logic [15:0] v, e, e2;
    wr(9, 16'h00E4);           // ch0 rise, ch1 fall, ch2 both, div 1
    wr(11, 16'h01FF);
    e = now16();
    ic_pin = 3'b111;
    repeat (3) @(negedge clk);
    rd(1, v); chk("R4 rise capture ch0", v, 16'(e + 2));
    rd(2, v); chk("R3 unselected rise ch1", v, 0);
    rd(3, v); chk("R3 both-edge rise ch2", v, 16'(e + 2));
    rd(11, v); chk("R3 capture flags", v & 16'h7, 16'h5);
    e2 = now16();
    ic_pin = 3'b000;
    repeat (3) @(negedge clk);
    rd(1, v); chk("R3 unselected fall ch0", v, 16'(e + 2));
    rd(2, v); chk("R4 fall capture ch1", v, 16'(e2 + 2));
    rd(3, v); chk("R3 both-edge fall ch2", v, 16'(e2 + 2));
    wr(9, 16'h00E0);           // ch0 disabled
    ic_pin[0] = 1'b1;
    repeat (4) @(negedge clk);
    rd(1, v); chk("R3 disabled ch0", v, 16'(e + 2));
  endtask

  task automatic t_compare();
    logic [15:0] v, tgt;
    act_sh = 16'h000C;         // ch1 set, ch2 none
    wr(10, act_sh);
    tgt = now16() + 16'd30;
    wr(5, tgt); wr(6, tgt);
    wr(11, 16'h01FF);
    wait_cnt(tgt);
    chk("R5 pin before event", oc_pin[1], 0);
    @(negedge clk);
    chk("R5 set action", oc_pin[1], 1);
    chk("R5 none action pin", oc_pin[2], 0);
    rd(11, v); chk("R5 flags ch1 ch2", (v >> 4) & 16'h3, 16'h3);
    act_sh[3:2] = 2'd2;        // ch1 clear
    wr(10, act_sh);
    tgt = now16() + 16'd30;
    wr(5, tgt);
    wait_cnt(tgt);
    chk("R5 held before clear", oc_pin[1], 1);
    @(negedge clk);
    chk("R5 clear action", oc_pin[1], 0);
  endtask

  task automatic t_pulse();
    logic [15:0] tgt;
    act_sh[1:0] = 2'd1;        // ch0 toggle
    wr(10, act_sh);
    tgt = now16() + 16'd30;
    wr(4, tgt);
    wait_cnt(tgt);
    we = 1'b1; addr = 4'd4; wdata = tgt + 16'd1;
    @(negedge clk);
    we = 1'b0;
    chk("R6 pulse high", oc_pin[0], 1);
    @(negedge clk);
    chk("R6 pulse one clock", oc_pin[0], 0);
    @(negedge clk);
    chk("R6 pulse stays low", oc_pin[0], 0);
  endtask

  task automatic t_irq();
    logic [15:0] v, tgt;
    wr(11, 16'h01FF);
    rd(11, v); chk("R8 all cleared", v, 0);
    wr(12, 16'h0010);          // enable ch1 compare flag only
    act_sh[3:2] = 2'd3;
    wr(10, act_sh);
    tgt = now16() + 16'd20;
    wr(5, tgt);
    wait_cnt(tgt);
    chk("R9 irq idle", irq, 0);
    @(negedge clk);
    chk("R9 irq registered delay", irq, 0);
    @(negedge clk);
    chk("R9 irq asserted", irq, 1);
    wr(11, 16'h0000);
    @(negedge clk);
    chk("R8 write zero keeps irq", irq, 1);
    rd(11, v); chk("R8 write zero keeps flag", (v >> 4) & 1, 1);
    wr(11, 16'h0010);
    @(negedge clk);
    chk("R9 irq drops after clear", irq, 0);
    rd(11, v); chk("R8 flag cleared", (v >> 4) & 1, 0);
    ic_pin[2] = ~ic_pin[2];
    repeat (4) @(negedge clk);
    rd(11, v); chk("R8 masked flag set", (v >> 2) & 1, 1);
    chk("R9 masked flag no irq", irq, 0);
  endtask

  task automatic t_overflow();
    logic [15:0] v;
    wr(11, 16'h01FF);
    wait_cnt(16'hFFFE);
    rd(11, v); chk("R7 no overflow yet", (v >> 8) & 1, 0);
    @(negedge clk);
    chk("R1 counter wrapped", now16(), 0);
    rd(11, v); chk("R7 overflow flag", (v >> 8) & 1, 1);
  endtask

  task automatic t_prescale();
    logic [15:0] a, b;
    logic [15:0] exp_d [4];
    exp_d[0] = 64; exp_d[1] = 16; exp_d[2] = 8; exp_d[3] = 4;
    for (int s = 0; s < 4; s++) begin
      wr(9, 16'(s));
      repeat (20) @(negedge clk);
      rd(0, a);
      repeat (63) @(negedge clk);
      rd(0, b);
      chk($sformatf("R2 divide code %0d", s), 16'(b - a), exp_d[s]);
    end
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_capture();
    t_compare();
    t_pulse();
    t_irq();
    t_overflow();
    t_prescale();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule